// File: doc/BRIEF.md
# Register-Programmed Clock Divider

The block divides its input clock by a divisor held in a bit field of a 32-bit control register. The register sits behind a minimal synchronous port with a write enable, write data and read data and no address. The field position and width are parameters, and a mode parameter picks the field-to-divisor encoding. There are four encodings: field plus one, field taken as the divisor directly, two raised to the field, and a small parameter table of field/divisor pairs.

A divisor that decodes to zero does not stop the output clock. The output then passes the input clock through, and a bypass flag is raised. A divisor of one also passes the input clock, but the bypass flag stays low. A parameter can switch the register to a half-word write-mask protocol: the upper half of the write data selects which bits of the lower half are written. A new divisor is adopted only when the running output period ends, so reprogramming never produces a shortened pulse.

Top module: `clkdiv_reg`

## Requirements
- R1: The field value is `(ctrl >> SHIFT) & (2**WIDTH - 1)`. No other register bit influences the divisor.
- R2: In mode 0 the divisor is the field value plus one.
- R3: In mode 1 the divisor equals the field value, so a field of zero yields divisor zero.
- R4: In mode 2 the divisor is 2 to the power of the field value.
- R5: In mode 3 the field is matched against the TBL_VAL entries, and entry i gives divisor TBL_DIV entry i. A field with no match yields divisor zero.
- R6: While the active divisor is zero, `clk_out` follows `clk` and `bypass` is 1. `div_valid` is 1 exactly when the register's current field decodes to a nonzero divisor.
- R7: For divisor N of at least 2, `clk_out` is high for ceil(N/2) input cycles and then low for floor(N/2) cycles. For N equal to 1, `clk_out` follows `clk` and `bypass` stays 0.
- R8: A divisor written in mid-period is adopted only after the current output period has completed in full.
- R9: With HALF_MASK=0, a write replaces only the divisor field. All other register bits keep their value.
- R10: With HALF_MASK=1, `wr_data[31:16]` are per-bit enables for `wr_data[15:0]`. Only enabled bits of register bits 15:0 change.
- R11: `rd_data` returns the stored register. With HALF_MASK=1, bits 31:16 read as zero.
- R12: While `rst_n` is low the register is zero, `clk_out` is low and `bypass` is 0.

Elaboration stops with an error in two cases: half-word mask mode with SHIFT+WIDTH above 16, and power-of-two mode whose largest divisor exceeds DIVW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Stored register contents |
| clk_out | output | 1 | Divided or passed-through clock |
| div_valid | output | 1 | Current field decodes to a nonzero divisor |
| bypass | output | 1 | Active divisor is zero; input clock passed through |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any write. They also assume that `wr_en` and `wr_data` change only between edges, so a write lands in exactly one cycle. The bench drives every input one nanosecond after a rising edge and holds reset for several cycles. Before it measures high and low phase lengths, it waits longer than the longest possible period, so the previous divisor has fully drained.

// File: rtl/clkdiv_reg.sv
module clkdiv_reg #(
  parameter int SHIFT     = 0,
  parameter int WIDTH     = 4,
  parameter int MODE      = 0,
  parameter int HALF_MASK = 0,
  parameter int DIVW      = 16,
  parameter int TBL_N     = 4,
  parameter logic [TBL_N*WIDTH-1:0] TBL_VAL = 16'h3210,
  parameter logic [TBL_N*DIVW-1:0]  TBL_DIV = {16'd10, 16'd6, 16'd5, 16'd3}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        clk_out,
  output logic        div_valid,
  output logic        bypass
);

  localparam logic [31:0] FMASK = ((32'd1 << WIDTH) - 32'd1) << SHIFT;

  generate
    if (HALF_MASK != 0 && SHIFT + WIDTH > 16) begin : g_bad_mask
      $error("half-word mask mode needs SHIFT+WIDTH <= 16");
    end
    if (MODE == 2 && (2 ** WIDTH) - 1 >= DIVW) begin : g_bad_pow
      $error("power-of-two divisor does not fit in DIVW bits");
    end
  endgenerate

  logic [31:0]      ctrl_q, ctrl_d;
  logic [WIDTH-1:0] fld;
  logic [DIVW-1:0]  dec, act_div, cnt, nxt_div, nxt_cnt;
  logic [DIVW:0]    half;
  logic             hit, boundary, div_hi, pass_q, byp_q;

  generate
    if (HALF_MASK != 0) begin : g_mask
      assign ctrl_d = {16'h0000, (ctrl_q[15:0] & ~wr_data[31:16]) | (wr_data[15:0] & wr_data[31:16])};
      // R10: a write with no enable bit set leaves the register untouched
      p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:16] == 16'h0000) |=> $stable(ctrl_q));
    end else begin : g_field
      assign ctrl_d = (ctrl_q & ~FMASK) | (wr_data & FMASK);
      // R9: bits outside the field never move
      p_field_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((ctrl_q & ~FMASK) == $past(ctrl_q & ~FMASK)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_d;
  end

  assign rd_data = ctrl_q;
  assign fld     = WIDTH'(ctrl_q >> SHIFT);

  always_comb begin
    dec = '0;
    hit = 1'b0;
    case (MODE)
      0: dec = DIVW'(fld) + DIVW'(1);
      1: dec = DIVW'(fld);
      2: dec = DIVW'(1) << fld;
      default: begin
        for (int i = 0; i < TBL_N; i++) begin
          if (!hit && TBL_VAL[i*WIDTH +: WIDTH] == fld) begin
            dec = TBL_DIV[i*DIVW +: DIVW];
            hit = 1'b1;
          end
        end
      end
    endcase
  end

  assign div_valid = (dec != '0);

  assign boundary = (act_div <= DIVW'(1)) || (cnt == act_div - DIVW'(1));
  assign nxt_div  = boundary ? dec : act_div;
  assign nxt_cnt  = boundary ? '0 : cnt + DIVW'(1);
  assign half     = ({1'b0, nxt_div} + (DIVW+1)'(1)) >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_div <= '0;
      cnt     <= '0;
      div_hi  <= 1'b0;
      pass_q  <= 1'b0;
      byp_q   <= 1'b0;
    end else begin
      act_div <= nxt_div;
      cnt     <= nxt_cnt;
      div_hi  <= (nxt_div >= DIVW'(2)) && ({1'b0, nxt_cnt} < half);
      pass_q  <= (nxt_div <= DIVW'(1));
      byp_q   <= (nxt_div == '0);
    end
  end

  assign clk_out = pass_q ? clk : div_hi;
  assign bypass  = byp_q;

  // R8: the divisor only changes once the count has reached the end of a period
  p_hold_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_div >= DIVW'(2) && cnt != act_div - DIVW'(1)) |=> $stable(act_div));
  // R7: the count stays inside the active period
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_div >= DIVW'(2)) |-> (cnt < act_div));
  // R7: each period starts high and ends low
  p_start_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && dec >= DIVW'(2)) |=> div_hi);
  p_end_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_div >= DIVW'(2) && cnt == act_div - DIVW'(1)) |-> !div_hi);
  // R6: a bypass always passes the input clock through
  p_bypass_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byp_q |-> pass_q);

  generate
    if (MODE == 2) begin : g_pow_chk
      // R4: an active power-of-two divisor has at most one bit set
      p_pow_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_div));
    end
  endgenerate

endmodule

// File: tb/clkdiv_reg_tb.sv
`timescale 1ns/1ps
module clkdiv_reg_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wdata = '0;
  logic        wren [4];
  logic [31:0] rds [4];
  logic        outs [4];
  logic        vld [4];
  logic        byp [4];
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  clkdiv_reg #(.SHIFT(4), .WIDTH(4), .MODE(0), .HALF_MASK(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wren[0]), .wr_data(wdata), .rd_data(rds[0]),
    .clk_out(outs[0]), .div_valid(vld[0]), .bypass(byp[0]));
  clkdiv_reg #(.SHIFT(2), .WIDTH(4), .MODE(1), .HALF_MASK(1)) u_dir (
    .clk(clk), .rst_n(rst_n), .wr_en(wren[1]), .wr_data(wdata), .rd_data(rds[1]),
    .clk_out(outs[1]), .div_valid(vld[1]), .bypass(byp[1]));
  clkdiv_reg #(.SHIFT(0), .WIDTH(3), .MODE(2), .HALF_MASK(0)) u_pow (
    .clk(clk), .rst_n(rst_n), .wr_en(wren[2]), .wr_data(wdata), .rd_data(rds[2]),
    .clk_out(outs[2]), .div_valid(vld[2]), .bypass(byp[2]));
  clkdiv_reg #(.SHIFT(8), .WIDTH(3), .MODE(3), .HALF_MASK(0),
               .TBL_VAL({3'd3, 3'd2, 3'd1, 3'd0}),
               .TBL_DIV({16'd10, 16'd6, 16'd5, 16'd3})) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(wren[3]), .wr_data(wdata), .rd_data(rds[3]),
    .clk_out(outs[3]), .div_valid(vld[3]), .bypass(byp[3]));

  // instance, field, high cycles, low cycles (0/0 = pass-through), bypass expected
  localparam int VEC [15][5] = '{
    '{0, 0, 0, 0, 0}, '{0, 3, 2, 2, 0}, '{0, 4, 3, 2, 0}, '{0, 15, 8, 8, 0},
    '{1, 1, 0, 0, 0}, '{1, 5, 3, 2, 0}, '{1, 0, 0, 0, 1},
    '{2, 0, 0, 0, 0}, '{2, 1, 1, 1, 0}, '{2, 3, 4, 4, 0}, '{2, 7, 64, 64, 0},
    '{3, 0, 2, 1, 0}, '{3, 2, 3, 3, 0}, '{3, 3, 5, 5, 0}, '{3, 4, 0, 0, 1}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic [31:0] d);
    wdata = d;
    wren[i] = 1'b1;
    @(posedge clk); #1;
    wren[i] = 1'b0;
  endtask

  function automatic logic [31:0] fdata(input int i, input int f);
    logic [31:0] r;
    case (i)
      0: r = 32'(f) << 4;
      1: r = (32'(f) << 2) | (32'h3C << 16);
      2: r = 32'(f);
      default: r = 32'(f) << 8;
    endcase
    return r;
  endfunction

  task automatic step(input int i, output logic v);
    @(posedge clk); #1;
    v = outs[i];
  endtask

  task automatic measure(input int i, output int hi, output int lo);
    logic v, p;
    hi = 0; lo = 0;
    step(i, p);
    for (int k = 0; k < 600; k++) begin
      step(i, v);
      if (!p && v) break;
      p = v;
    end
    hi = 1;
    for (int k = 0; k < 600; k++) begin step(i, v); if (!v) break; hi++; end
    lo = 1;
    for (int k = 0; k < 600; k++) begin step(i, v); if (v) break; lo++; end
  endtask

  task automatic check_pass(input int i, input string req);
    int bad = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1; if (outs[i] !== 1'b0) bad++;
      @(posedge clk); #1; if (outs[i] !== 1'b1) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int hi, lo, bad;
    logic v;
    for (int i = 0; i < 4; i++) wren[i] = 1'b0;
    // R12: reset state
    repeat (3) @(posedge clk);
    bad = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      for (int i = 0; i < 4; i++) if (outs[i] !== 1'b0 || byp[i] !== 1'b0 || rds[i] !== 32'h0) bad++;
      @(posedge clk); #1;
      for (int i = 0; i < 4; i++) if (outs[i] !== 1'b0) bad++;
    end
    chk(bad == 0, "R12 reset state", bad, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1..R7: encoding and duty vectors
    for (int n = 0; n < 15; n++) begin
      int i, f, eh, el, eb;
      i = VEC[n][0]; f = VEC[n][1]; eh = VEC[n][2]; el = VEC[n][3]; eb = VEC[n][4];
      wr(i, fdata(i, f));
      chk(vld[i] == (eb == 0), "R6 div_valid", int'(vld[i]), int'(eb == 0));
      repeat (300) @(posedge clk);
      #1;
      chk(byp[i] == eb[0], "R6 bypass flag", int'(byp[i]), eb);
      if (eh == 0) begin
        check_pass(i, eb != 0 ? "R6 zero-divisor pass" : "R7 divide-by-one pass");
      end else begin
        measure(i, hi, lo);
        chk(hi == eh, i == 0 ? "R1/R2 high phase" : i == 1 ? "R3 high phase" :
                      i == 2 ? "R4 high phase" : "R5 high phase", hi, eh);
        chk(lo == el, "R7 low phase", lo, el);
      end
    end

    // R8: mid-period reprogram completes the running period
    wr(0, fdata(0, 15));
    repeat (300) @(posedge clk);
    #1;
    step(0, v);
    for (int k = 0; k < 600; k++) begin
      logic p;
      p = v;
      step(0, v);
      if (!p && v) break;
    end
    hi = 1;
    step(0, v); if (v) hi++;
    step(0, v); if (v) hi++;
    wdata = fdata(0, 3); wren[0] = 1'b1;
    @(posedge clk); #1; wren[0] = 1'b0; v = outs[0]; if (v) hi++;
    for (int k = 0; k < 40 && v; k++) begin step(0, v); if (v) hi++; end
    chk(hi == 8, "R8 old high phase kept", hi, 8);
    lo = 1;
    for (int k = 0; k < 40; k++) begin step(0, v); if (v) break; lo++; end
    chk(lo == 8, "R8 old low phase kept", lo, 8);
    hi = 1;
    for (int k = 0; k < 40; k++) begin step(0, v); if (!v) break; hi++; end
    chk(hi == 2, "R8 new divisor adopted", hi, 2);

    // R9: plain write only touches the field
    wr(0, 32'hFFFF_FFFF);
    chk(rds[0] == 32'h0000_00F0, "R9 field-only write", int'(rds[0]), 32'hF0);
    wr(0, 32'hFFFF_FF2F);
    chk(rds[0] == 32'h0000_0020, "R1/R9 field rewrite", int'(rds[0]), 32'h20);

    // R10/R11: half-word mask protocol on u_dir (register holds 0 here)
    wr(1, 32'h0000_FFFF);
    chk(rds[1] == 32'h0, "R10 no enables no change", int'(rds[1]), 0);
    wr(1, 32'h8003_FFFF);
    chk(rds[1] == 32'h0000_8003, "R10/R11 masked write", int'(rds[1]), 32'h8003);
    wr(1, 32'h0001_0000);
    chk(rds[1] == 32'h0000_8002, "R10 masked clear", int'(rds[1]), 32'h8002);
    wr(1, 32'hFFFF_0014);
    chk(rds[1][31:16] == 16'h0, "R11 upper half zero", int'(rds[1][31:16]), 0);
    chk(rds[1] == 32'h0000_0014, "R11 readback", int'(rds[1]), 32'h14);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule